// File: doc/BRIEF.md
# DDR SDRAM Clock-Enable Power-State Tracker

This block follows the low-power state of a DDR SDRAM device by watching the clock-enable line and the command seen on each rising clock edge. It keeps a registered copy of clock-enable, so every edge is judged from the pair (earlier sample, present sample). That pair, the decoded command and the state held just before the edge together choose the next state. The block enters and leaves the two power-down modes and self refresh, and it flags any combination of inputs that has no defined meaning.

After a self-refresh exit, two waits start together. The exit window is short and set by a parameter in clock cycles; while it runs, only no-operation or deselect commands are accepted. The delay-locked-loop settling wait is longer, and the read-permitted output stays low until it has elapsed. A controller model or a protocol monitor can use the outputs to gate its own command issue, or to report a misuse of the clock-enable line.

Top module: `cke_pwr_tracker`

## Requirements
- R1: A synchronous active-high reset sets the state to all-banks-idle (code 0), clears the illegal and exit flags, raises read-permitted and records the earlier clock-enable sample as high.
- R2: State codes are idle=0, active=1, precharge power-down=2, active power-down=3, self refresh=4. Commands decode as NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), deselect (cs_n=1), auto refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1). Every other strobe pattern is a different command.
- R3: With clock-enable high on both the earlier and the present edge, an awake state becomes active if bank_open is 1 and idle if it is 0, and no flag is raised.
- R4: On a high-to-low clock-enable change with NOP or deselect, idle goes to precharge power-down and active goes to active power-down.
- R5: On a high-to-low clock-enable change with auto refresh in the idle state, the state becomes self refresh.
- R6: In either power-down state or in self refresh, clock-enable low on both edges keeps the state, whatever the command.
- R7: A low-to-high clock-enable change with NOP or deselect takes precharge power-down back to idle and active power-down back to active.
- R8: A low-to-high clock-enable change with NOP or deselect in self refresh goes to idle. exit_busy is then high for exactly TXSNR_CYC cycles (default 10).
- R9: After a self-refresh exit edge, read_ok is low for exactly DLL_LOCK_CYC cycles (default 200) and high after that.
- R10: While exit_busy is high, any command other than NOP or deselect raises illegal and keeps the state.
- R11: Any other combination of state, clock-enable pair and command raises illegal for that edge and keeps the state. illegal falls again after the next legal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable line of the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_open | input | 1 | High when one or more banks are open |
| pwr_state | output | 3 | Current power state code (R2) |
| illegal | output | 1 | High for the edge after an undefined combination |
| exit_busy | output | 1 | Self-refresh exit window running |
| read_ok | output | 1 | Reads allowed; low during the DLL settling wait |

## Verification
The hardest cases to reach are those where the clock-enable history and the state disagree. Examples are a rising edge in an awake state, or a falling edge while the device is already powered down. Neither can happen on a legal sequence. The stimulus reaches them by first issuing a non-quiet command on a clock-enable change. That edge is rejected, so the state stays put while the history register moves, and the following edge then lands on the mismatched pair. The long settling wait is checked cycle by cycle from the exit edge, so that an off-by-one at either end of either window is caught.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_ACTIVE   = 3'd1,
        PS_PRE_PD   = 3'd2,
        PS_ACT_PD   = 3'd3,
        PS_SELF_REF = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_DESEL = 2'd1,
        CMD_AREF  = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        EDGE_HOLD_HI = 2'd0,
        EDGE_FALL    = 2'd1,
        EDGE_RISE    = 2'd2,
        EDGE_HOLD_LO = 2'd3
    } cke_edge_e;

    typedef struct packed {
        pwr_state_e nxt;
        logic       bad;
        logic       sr_exit;
    } step_t;

    function automatic cmd_kind_e decode_cmd(input logic cs_n, input logic ras_n,
                                             input logic cas_n, input logic we_n);
        if (cs_n)                              return CMD_DESEL;
        if (ras_n && cas_n && we_n)            return CMD_NOP;
        if (!ras_n && !cas_n && we_n)          return CMD_AREF;
        return CMD_OTHER;
    endfunction

    function automatic logic is_quiet(input cmd_kind_e c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

    function automatic logic is_low_power(input pwr_state_e s);
        return (s == PS_PRE_PD) || (s == PS_ACT_PD) || (s == PS_SELF_REF);
    endfunction

    function automatic cke_edge_e classify_edge(input logic prev, input logic now);
        case ({prev, now})
            2'b11:   return EDGE_HOLD_HI;
            2'b10:   return EDGE_FALL;
            2'b01:   return EDGE_RISE;
            default: return EDGE_HOLD_LO;
        endcase
    endfunction

endpackage

// File: rtl/cke_edge_track.sv
module cke_edge_track
    import cke_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    output logic      cke_q,
    output cke_edge_e edge_kind
);
    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end

    assign edge_kind = classify_edge(cke_q, cke);
endmodule

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
    import cke_pwr_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output cmd_kind_e cmd,
    output logic      quiet
);
    always_comb begin
        cmd   = decode_cmd(cs_n, ras_n, cas_n, we_n);
        quiet = is_quiet(cmd);
    end
endmodule

// File: rtl/cke_wait_timer.sv
module cke_wait_timer #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= LOAD_VAL;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
    import cke_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cke_edge_e  edge_kind,
    input  cmd_kind_e  cmd,
    input  logic       quiet,
    input  logic       bank_open,
    input  logic       exit_busy,
    output pwr_state_e state,
    output logic       illegal,
    output logic       sr_exit
);
    step_t step;

    always_comb begin
        step.nxt     = state;
        step.bad     = 1'b0;
        step.sr_exit = 1'b0;
        case (edge_kind)
            EDGE_HOLD_HI: begin
                if (is_low_power(state)) step.bad = 1'b1;
                else step.nxt = bank_open ? PS_ACTIVE : PS_IDLE;
            end
            EDGE_FALL: begin
                if (state == PS_IDLE && quiet)                 step.nxt = PS_PRE_PD;
                else if (state == PS_IDLE && cmd == CMD_AREF)  step.nxt = PS_SELF_REF;
                else if (state == PS_ACTIVE && quiet)          step.nxt = PS_ACT_PD;
                else                                           step.bad = 1'b1;
            end
            EDGE_HOLD_LO: begin
                if (!is_low_power(state)) step.bad = 1'b1;
            end
            default: begin
                if (!quiet) step.bad = 1'b1;
                else begin
                    case (state)
                        PS_SELF_REF: begin
                            step.nxt     = PS_IDLE;
                            step.sr_exit = 1'b1;
                        end
                        PS_PRE_PD: step.nxt = PS_IDLE;
                        PS_ACT_PD: step.nxt = PS_ACTIVE;
                        default:   step.bad = 1'b1;
                    endcase
                end
            end
        endcase
        if (exit_busy && !quiet) step.bad = 1'b1;
        if (step.bad) begin
            step.nxt     = state;
            step.sr_exit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            illegal <= 1'b0;
        end else begin
            state   <= step.nxt;
            illegal <= step.bad;
        end
    end

    assign sr_exit = step.sr_exit;
endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
    import cke_pwr_pkg::*;
#(
    parameter int TXSNR_CYC    = 10,
    parameter int DLL_LOCK_CYC = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       bank_open,
    output logic [2:0] pwr_state,
    output logic       illegal,
    output logic       exit_busy,
    output logic       read_ok
);
    logic       cke_q;
    cke_edge_e  edge_kind;
    cmd_kind_e  cmd;
    logic       quiet;
    pwr_state_e state;
    logic       sr_exit;
    logic       dll_wait;

    cke_edge_track u_edge (
        .clk(clk), .rst(rst), .cke(cke), .cke_q(cke_q), .edge_kind(edge_kind)
    );

    cke_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd(cmd), .quiet(quiet)
    );

    cke_pwr_fsm u_fsm (
        .clk(clk), .rst(rst), .edge_kind(edge_kind), .cmd(cmd), .quiet(quiet),
        .bank_open(bank_open), .exit_busy(exit_busy),
        .state(state), .illegal(illegal), .sr_exit(sr_exit)
    );

    cke_wait_timer #(.LEN(TXSNR_CYC)) u_xsnr (
        .clk(clk), .rst(rst), .load(sr_exit), .busy(exit_busy)
    );

    cke_wait_timer #(.LEN(DLL_LOCK_CYC)) u_dll (
        .clk(clk), .rst(rst), .load(sr_exit), .busy(dll_wait)
    );

    assign pwr_state = state;
    assign read_ok   = !dll_wait;
endmodule

// File: rtl/cke_pwr_tracker_chk.sv
module cke_pwr_tracker_chk #(
    parameter int TXSNR_CYC    = 10,
    parameter int DLL_LOCK_CYC = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic       cke_q,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [2:0] pwr_state,
    input logic       illegal,
    input logic       exit_busy,
    input logic       read_ok
);
    logic nop_or_des, aref;
    assign nop_or_des = cs_n || (ras_n && cas_n && we_n);
    assign aref       = !cs_n && !ras_n && !cas_n && we_n;

    // R2: only defined codes appear
    a_r2_state_code: assert property (@(posedge clk) disable iff (rst)
        pwr_state <= 3'd4);

    a_r4_pre_pd_entry: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd0 && cke_q && !cke && nop_or_des && !exit_busy)
        |=> (pwr_state == 3'd2 && !illegal));

    a_r5_sr_entry: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd0 && cke_q && !cke && aref && !exit_busy)
        |=> (pwr_state == 3'd4));

    a_r6_hold_low: assert property (@(posedge clk) disable iff (rst)
        (pwr_state >= 3'd2 && pwr_state <= 3'd4 && !cke_q && !cke) |=> $stable(pwr_state));

    a_r8_exit_start: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd4 && !cke_q && cke && nop_or_des)
        |=> (pwr_state == 3'd0 && exit_busy && !read_ok));

    generate
        if (TXSNR_CYC <= DLL_LOCK_CYC) begin : g_order
            a_r9_no_read_in_exit: assert property (@(posedge clk) disable iff (rst)
                exit_busy |-> !read_ok);
        end
    endgenerate

    a_r10_window_cmd: assert property (@(posedge clk) disable iff (rst)
        (exit_busy && !nop_or_des) |=> illegal);

    a_r11_keep_on_illegal: assert property (@(posedge clk) disable iff (rst)
        (illegal && !$past(rst)) |-> $stable(pwr_state));
endmodule

bind cke_pwr_tracker cke_pwr_tracker_chk #(
    .TXSNR_CYC(TXSNR_CYC), .DLL_LOCK_CYC(DLL_LOCK_CYC)
) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cke_q(cke_q), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .pwr_state(pwr_state), .illegal(illegal),
    .exit_busy(exit_busy), .read_ok(read_ok)
);

// File: tb/cke_pwr_tracker_test.sv
`timescale 1ns/1ps
module cke_pwr_tracker_test;
    localparam int TX  = 10;
    localparam int DLL = 200;
    localparam int NV  = 20;

    // vector: {cke, cmd[1:0], bank, exp_state[2:0], exp_illegal}
    // cmd: 0 NOP, 1 deselect, 2 auto refresh, 3 other (read)
    localparam logic [7:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b0},  // R3 idle
        {1'b1, 2'd0, 1'b1, 3'd1, 1'b0},  // R3 active
        {1'b0, 2'd0, 1'b1, 3'd3, 1'b0},  // R4 active power-down
        {1'b0, 2'd3, 1'b1, 3'd3, 1'b0},  // R6 hold
        {1'b1, 2'd0, 1'b1, 3'd1, 1'b0},  // R7 back to active
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b0},  // R3 idle
        {1'b0, 2'd1, 1'b0, 3'd2, 1'b0},  // R4 precharge power-down
        {1'b0, 2'd2, 1'b0, 3'd2, 1'b0},  // R6 hold
        {1'b1, 2'd3, 1'b0, 3'd2, 1'b1},  // R11 rise with read
        {1'b0, 2'd0, 1'b0, 3'd2, 1'b1},  // R11 fall while powered down
        {1'b1, 2'd1, 1'b0, 3'd0, 1'b0},  // R7 back to idle
        {1'b0, 2'd2, 1'b0, 3'd4, 1'b0},  // R5 self refresh
        {1'b0, 2'd3, 1'b0, 3'd4, 1'b0},  // R6 hold
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b0},  // R8 exit
        {1'b1, 2'd3, 1'b0, 3'd0, 1'b1},  // R10 read in window
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b0},  // R10 quiet in window
        {1'b0, 2'd3, 1'b0, 3'd0, 1'b1},  // R11 fall with read
        {1'b0, 2'd0, 1'b0, 3'd0, 1'b1},  // R11 low-low while awake
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b1},  // R11 rise while awake
        {1'b1, 2'd0, 1'b0, 3'd0, 1'b0}   // R3 recovered
    };

    logic clk = 1'b0;
    logic rst, cke, cs_n, ras_n, cas_n, we_n, bank_open;
    logic [2:0] pwr_state;
    logic illegal, exit_busy, read_ok;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cke_pwr_tracker #(.TXSNR_CYC(TX), .DLL_LOCK_CYC(DLL)) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .bank_open(bank_open),
        .pwr_state(pwr_state), .illegal(illegal), .exit_busy(exit_busy),
        .read_ok(read_ok)
    );

    task automatic set_cmd(input logic [1:0] c);
        case (c)
            2'd0: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            2'd1: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            2'd2: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
        endcase
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, sample at the next falling edge
    task automatic step(input logic k, input logic [1:0] c, input logic b);
        cke = k; set_cmd(c); bank_open = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; cke = 1'b1; set_cmd(2'd0); bank_open = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", "state", int'(pwr_state), 0);
        check("R1", "illegal", int'(illegal), 0);
        check("R1", "exit_busy", int'(exit_busy), 0);
        check("R1", "read_ok", int'(read_ok), 1);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6:5], VEC[i][4]);
            check("R2-table", $sformatf("vec%0d state", i), int'(pwr_state), int'(VEC[i][3:1]));
            check("R11-table", $sformatf("vec%0d illegal", i), int'(illegal), int'(VEC[i][0]));
        end

        // R1: history starts high, so a first low sample is a falling edge
        do_reset();
        step(1'b0, 2'd0, 1'b0);
        check("R1", "history high -> power-down", int'(pwr_state), 2);
        check("R4", "no flag", int'(illegal), 0);

        // R8 / R9: exit window and DLL wait, cycle by cycle
        do_reset();
        step(1'b0, 2'd2, 1'b0);
        check("R5", "enter self refresh", int'(pwr_state), 4);
        step(1'b0, 2'd1, 1'b0);
        check("R6", "stay self refresh", int'(pwr_state), 4);
        check("R9", "read_ok before exit", int'(read_ok), 1);
        for (int i = 1; i <= DLL + 3; i++) begin
            step(1'b1, 2'd0, 1'b0);
            check("R8", $sformatf("exit_busy cyc%0d", i), int'(exit_busy), int'(i <= TX));
            check("R9", $sformatf("read_ok cyc%0d", i), int'(read_ok), int'(i > DLL));
            if (i == 1) check("R8", "state after exit", int'(pwr_state), 0);
        end

        // R10: last cycle of the window still rejects, first after it accepts
        do_reset();
        step(1'b0, 2'd2, 1'b0);
        step(1'b1, 2'd1, 1'b0);
        for (int i = 2; i <= TX; i++) step(1'b1, 2'd0, 1'b1);
        check("R3", "active during window", int'(pwr_state), 1);
        step(1'b1, 2'd3, 1'b0);
        check("R10", "read at window end", int'(illegal), 1);
        check("R10", "state kept", int'(pwr_state), 1);
        step(1'b1, 2'd3, 1'b0);
        check("R10", "read after window", int'(illegal), 0);
        check("R3", "follows bank flag", int'(pwr_state), 0);

        // R11: auto refresh with banks open on falling edge
        do_reset();
        step(1'b1, 2'd0, 1'b1);
        step(1'b0, 2'd2, 1'b1);
        check("R11", "aref from active", int'(illegal), 1);
        check("R11", "state kept", int'(pwr_state), 1);

        finish_run();
    end
endmodule